// File: doc/BRIEF.md
# Hold and Task-Wakeup Fault Injector

This block stresses a multitasking microsequencer by injecting external holds and timed task wakeups. One 16-bit control word is loaded into it. The upper byte seeds an 8-bit pattern that rotates once per instruction cycle. Whenever a 1 reaches the top bit of the pattern, an external hold is asserted two instruction cycles later. The lower byte configures a small wakeup timer. Bit 0 arms the timer and bits 3:1 give the starting count. The timer counts instruction cycles and, at terminal count, raises a one-cycle wakeup request for a dedicated simulator task.

The woken task must rearm the timer before it blocks. Until it does, no further wakeup occurs. Loading all zeros stops both mechanisms. Zeros that are already in flight through the hold latency stages drain after a few more instruction cycles, which is why software clears the block by writing zero several times. A polyphase-operation inhibit input gates the hold output off, because holds cannot overlap such operations.

Top module: `hold_wake_injector`

## Requirements
- R1: After reset, `hold_o` and `wake_o` are 0, the hold pattern is zero and the timer is disarmed.
- R2: A load copies `load_data_i[15:8]` into the hold pattern. The first `step_i` after a load does not rotate the pattern.
- R3: Every later `step_i` rotates the pattern left by one position, with bit 7 wrapping into bit 0.
- R4: `hold_o` equals the value that pattern bit 7 had two `step_i` cycles earlier. Each step moves that value one stage through a two-stage delay.
- R5: While `inhibit_i` is 1, `hold_o` is 0 in the same cycle, whatever the pattern holds.
- R6: In a cycle with `step_i` at 0 and no load or rearm, neither the hold pattern, the delay stages nor the timer changes.
- R7: A load copies `load_data_i[3:0]` into the timer. Bit 0 is the enable and bits 3:1 are the start count c. When the timer is enabled, each step increments the count. The step taken at count 7 (that is, the (8-c)-th step after the load) makes `wake_o` high in the following cycle.
- R8: `wake_o` is a single-cycle pulse. After firing, the timer stays disarmed and gives no further pulse until it is rearmed or reloaded.
- R9: `rearm_i` reloads the timer from the last loaded task field. The next wakeup therefore needs the same number of steps as it did after that load.
- R10: Loading 16'h0000 stops wakeups at once. `hold_o` is 0 from the third step after the zero load onward.
- R11: A task field with bit 0 clear never produces `wake_o`, whatever number of steps follows.
- R12: Load has priority over rearm, and rearm has priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | One instruction cycle elapsed |
| load_i | input | 1 | Load control word |
| load_data_i | input | 16 | Control word: [15:8] hold pattern, [3:0] task field |
| inhibit_i | input | 1 | Polyphase operation in progress; gates hold off |
| rearm_i | input | 1 | Simulator task rearms the timer before blocking |
| hold_o | output | 1 | External hold request |
| wake_o | output | 1 | One-cycle wakeup request for the simulator task |

## Verification
The bench loads a single-bit pattern at bit 6 and watches when the hold first appears. A design that rotated on the step right after a load would assert it one step early. Start counts 6 and 7 exercise the shortest wakeup delays and the stop after firing. A timer that re-fired without a rearm, or that rearmed from its current count, would pulse at the wrong cycle. Repeated zero loads with delay stages still full check the drain behaviour. A random phase then mixes loads, rearms, idle cycles and inhibit against a reference model.

// File: rtl/hwi_pkg.sv
package hwi_pkg;
  localparam int unsigned DEF_HOLD_W = 8;
  localparam int unsigned DEF_HOLD_LAT = 2;
  localparam int unsigned DEF_CNT_W = 3;

  typedef enum logic [0:0] {
    TMR_IDLE  = 1'b0,
    TMR_ARMED = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/hold_ring.sv
module hold_ring #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic         tap_o
);
  logic [W-1:0] ring_q;
  logic         skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
      skip_q <= 1'b0;
    end else if (load_i) begin
      ring_q <= seed_i;
      skip_q <= 1'b1;
    end else if (step_i) begin
      if (skip_q) skip_q <= 1'b0;
      else        ring_q <= {ring_q[W-2:0], ring_q[W-1]};
    end
  end

  assign tap_o = ring_q[W-1];

  p_skip_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_q && step_i && !load_i) |=> ($stable(ring_q) && !skip_q));
  p_rotate_keeps_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!skip_q && step_i && !load_i) |=> ($countones(ring_q) == $countones($past(ring_q))));
  p_idle_ring_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(ring_q));
endmodule

// File: rtl/hold_delay.sv
module hold_delay #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic tap_i,
  input  logic inhibit_i,
  output logic hold_o
);
  logic [LAT-1:0] pipe_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (step_i) pipe_q <= tap_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (step_i) pipe_q <= {pipe_q[LAT-2:0], tap_i};
      end
    end
  endgenerate

  assign hold_o = pipe_q[LAT-1] & ~inhibit_i;

  p_inhibit_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> !hold_o);
  p_first_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (pipe_q[0] == $past(tap_i)));
  p_idle_pipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pipe_q));
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import hwi_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [CNT_W:0] cfg_i,
  input  logic         rearm_i,
  output logic         wake_o
);
  localparam logic [CNT_W-1:0] TERM = '1;

  logic [CNT_W:0]   cfg_q;
  logic [CNT_W-1:0] cnt_q;
  tmr_state_e       state_q;
  logic             wake_q;
  logic             fire;

  assign fire = step_i && !load_i && !rearm_i && (state_q == TMR_ARMED) && (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      state_q <= TMR_IDLE;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= fire;
      if (load_i) begin
        cfg_q   <= cfg_i;
        cnt_q   <= cfg_i[CNT_W:1];
        state_q <= cfg_i[0] ? TMR_ARMED : TMR_IDLE;
      end else if (rearm_i) begin
        cnt_q   <= cfg_q[CNT_W:1];
        state_q <= cfg_q[0] ? TMR_ARMED : TMR_IDLE;
      end else if (step_i && state_q == TMR_ARMED) begin
        if (cnt_q == TERM) state_q <= TMR_IDLE;
        else               cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign wake_o = wake_q;

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_idle_no_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_IDLE) |=> !wake_o);
  p_load_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !wake_o);
  p_idle_timer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !rearm_i) |=> ($stable(cnt_q) && $stable(state_q)));
endmodule

// File: rtl/hold_wake_injector.sv
module hold_wake_injector
  import hwi_pkg::*;
#(
  parameter int unsigned HOLD_W   = DEF_HOLD_W,
  parameter int unsigned HOLD_LAT = DEF_HOLD_LAT,
  parameter int unsigned CNT_W    = DEF_CNT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  step_i,
  input  logic                  load_i,
  input  logic [2*HOLD_W-1:0]   load_data_i,
  input  logic                  inhibit_i,
  input  logic                  rearm_i,
  output logic                  hold_o,
  output logic                  wake_o
);
  localparam int unsigned WORD_W = 2 * HOLD_W;

  logic tap;

  hold_ring #(.W(HOLD_W)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_i),
    .load_i(load_i),
    .seed_i(load_data_i[WORD_W-1:HOLD_W]),
    .tap_o (tap)
  );

  hold_delay #(.LAT(HOLD_LAT)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .tap_i    (tap),
    .inhibit_i(inhibit_i),
    .hold_o   (hold_o)
  );

  wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .load_i (load_i),
    .cfg_i  (load_data_i[CNT_W:0]),
    .rearm_i(rearm_i),
    .wake_o (wake_o)
  );

  p_rearm_no_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !wake_o);
endmodule

// File: tb/hold_wake_injector_tb.sv
`timescale 1ns/1ps
module hold_wake_injector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, load = 1'b0, inh = 1'b0, rearm = 1'b0;
  logic [15:0] data = '0;
  logic        hold_o, wake_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_ring;
  logic       m_skip, m_p0, m_p1, m_arm, m_wake;
  logic [3:0] m_cfg;
  logic [2:0] m_cnt;

  always #2 clk = ~clk;

  hold_wake_injector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .load_i(load),
    .load_data_i(data), .inhibit_i(inh), .rearm_i(rearm),
    .hold_o(hold_o), .wake_o(wake_o)
  );

  function automatic logic exp_hold();
    return m_p1 & ~inh;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ring = '0; m_skip = 0; m_p0 = 0; m_p1 = 0;
    m_arm = 0; m_wake = 0; m_cfg = '0; m_cnt = '0;
  endtask

  // R2..R12 model update for one edge, from pre-edge state and driven inputs
  task automatic model_edge();
    logic fire;
    fire = step && !load && !rearm && m_arm && (m_cnt == 3'd7);
    if (step) begin m_p1 = m_p0; m_p0 = m_ring[7]; end
    if (load) begin m_ring = data[15:8]; m_skip = 1; end
    else if (step) begin
      if (m_skip) m_skip = 0;
      else m_ring = {m_ring[6:0], m_ring[7]};
    end
    m_wake = fire;
    if (load) begin m_cfg = data[3:0]; m_cnt = data[3:1]; m_arm = data[0]; end
    else if (rearm) begin m_cnt = m_cfg[3:1]; m_arm = m_cfg[0]; end
    else if (step && m_arm) begin
      if (m_cnt == 3'd7) m_arm = 0; else m_cnt = m_cnt + 3'd1;
    end
  endtask

  task automatic cyc(input string th, input string tw, input logic s, input logic l,
                     input logic [15:0] d, input logic i, input logic r);
    step = s; load = l; data = d; inh = i; rearm = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(th, hold_o, exp_hold(), "hold_o");
    check(tw, wake_o, m_wake, "wake_o");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", hold_o, 1'b0, "hold_o reset");
    check("R1", wake_o, 1'b0, "wake_o reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4: bit 6 seed reaches hold on 4th step (no rotate right after load)
    cyc("R2", "R11", 0, 1, 16'h4000, 0, 0);
    for (int k = 0; k < 3; k++) cyc("R2", "R11", 1, 0, 16'h0, 0, 0);
    check("R2", hold_o, 1'b0, "hold before 4th step");
    cyc("R4", "R11", 1, 0, 16'h0, 0, 0);
    check("R4", hold_o, 1'b1, "hold at 4th step");
    cyc("R5", "R11", 0, 0, 16'h0, 1, 0);
    check("R5", hold_o, 1'b0, "inhibited hold");
    cyc("R6", "R11", 0, 0, 16'h0, 0, 0);
    check("R6", hold_o, 1'b1, "hold kept without step");
    for (int k = 0; k < 10; k++) cyc("R3", "R11", 1, 0, 16'h0, 0, 0);

    // R11: enable clear, count 7
    cyc("R4", "R11", 0, 1, 16'h000E, 0, 0);
    for (int k = 0; k < 12; k++) cyc("R4", "R11", 1, 0, 16'h0, 0, 0);

    // R7/R8/R9: count 6 fires on 2nd step
    cyc("R4", "R7", 0, 1, 16'h000D, 0, 0);
    cyc("R4", "R7", 1, 0, 16'h0, 0, 0);
    check("R7", wake_o, 1'b0, "no wake after 1st step");
    cyc("R4", "R7", 1, 0, 16'h0, 0, 0);
    check("R7", wake_o, 1'b1, "wake after 2nd step");
    for (int k = 0; k < 6; k++) cyc("R4", "R8", 1, 0, 16'h0, 0, 0);
    cyc("R4", "R9", 0, 0, 16'h0, 0, 1);
    cyc("R4", "R9", 1, 0, 16'h0, 0, 0);
    cyc("R4", "R9", 1, 0, 16'h0, 0, 0);
    check("R9", wake_o, 1'b1, "wake after rearm");
    // R12: load and rearm together at terminal count
    cyc("R4", "R12", 0, 1, 16'h000F, 0, 0);
    cyc("R4", "R12", 1, 1, 16'h0005, 0, 1);
    for (int k = 0; k < 6; k++) cyc("R4", "R12", 1, 0, 16'h0, 0, 0);
    check("R12", wake_o, 1'b1, "wake from loaded count 2");

    // R10: fill with ones, then zero loads
    cyc("R4", "R7", 0, 1, 16'hFF01, 0, 0);
    for (int k = 0; k < 3; k++) cyc("R4", "R7", 1, 0, 16'h0, 0, 0);
    check("R4", hold_o, 1'b1, "ones pattern hold");
    cyc("R10", "R10", 1, 1, 16'h0000, 0, 0);
    cyc("R10", "R10", 1, 1, 16'h0000, 0, 0);
    cyc("R10", "R10", 1, 1, 16'h0000, 0, 0);
    check("R10", hold_o, 1'b0, "hold cleared");
    for (int k = 0; k < 10; k++) cyc("R10", "R10", 1, 0, 16'h0, 0, 0);
    check("R10", wake_o, 1'b0, "no wake after zero");

    // random phase
    void'($urandom(32'hC0FFEE));
    for (int k = 0; k < 3000; k++) begin
      logic s, l, i, r;
      logic [15:0] d;
      s = ($urandom % 4) != 0;
      l = ($urandom % 24) == 0;
      i = ($urandom % 8) == 0;
      r = ($urandom % 12) == 0;
      d = 16'($urandom);
      cyc("R4", "R7", s, l, d, i, r);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule